// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast reference clock into a stream of one-cycle enable pulses at sixteen times a serial bit rate. The ratio between the reference clock and the bit rate seldom divides evenly, so the divisor is a fixed-point number. It has a 16-bit whole part and a 6-bit fraction counted in sixty-fourths. Each tick period lasts either the whole part or one cycle longer, and the longer periods are spread out so that their average equals the programmed ratio.

A 6-bit accumulator adds the fraction once at the start of every period. A carry out of the accumulator stretches that period by one reference cycle. The divisor inputs are sampled only at a period boundary, or continuously while the generator is stopped, so software may change them at any time without producing a broken period. A whole part of zero stops the pulses. No derived clock is produced: the tick is a plain enable for downstream serial logic running on the reference clock.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, and after it until `en` is high, `tick` is low.
- R2: While `en` is low, `tick` stays low. A cycle with `en` low abandons the period in progress and clears the fractional accumulator to 0, so the next enabled run starts as if from reset.
- R3: A period lasts L = I + c cycles, where I is `div_int` and c is the accumulator carry for that period. `tick` is high in the last cycle of each period. If `en` is first high in cycle n, and a nonzero I is present in cycle n, the first tick is high in cycle n + L.
- R4: At each period start with I nonzero, the 6-bit accumulator adds `div_frac` F. c is 1 when the sum reaches 64, and the accumulator keeps the sum modulo 64. Across any 64 consecutive periods with a constant divisor, starting from accumulator 0, the periods total 64·I + F cycles.
- R5: A whole part of zero produces no ticks and leaves the accumulator unchanged. It is re-evaluated every cycle, so when a nonzero I appears in cycle n, the first tick is high in cycle n + L.
- R6: The divisor present in a tick cycle governs the next period. A divisor change in any other cycle has no effect on the period in progress.
- R7: `tick` is high for exactly one cycle per period, and periods follow each other with no gap. With I = 1 and F = 0, `tick` is high in every cycle.
- R8: The whole 16-bit range of I is honoured: I = 65535 with F = 0 gives a 65535-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable. Low stops the generator and clears its state |
| div_int | input | 16 | Whole part I of the divisor |
| div_frac | input | 6 | Fractional part F of the divisor, in 1/64 units |
| tick | output | 1 | One-cycle pulse at sixteen times the bit rate |

## Verification
After a start or a boundary, the next tick is due exactly L cycles later. L is I or I + 1, as set by the carry that the bench works out from its own accumulator model. Every boundary after the first lies exactly one period length past the previous tick. The bench drives inputs and samples `tick` on falling edges, and stamps each sample with the count of rising edges so far. Its driver tasks push the exact cycle number of every expected tick into a queue. The monitor fails any tick that arrives in another cycle, and any queued tick whose cycle passes without one. That covers a late tick, an early tick, a missing tick and an extra tick.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int INT_W = 16;
    localparam int FRAC_W = 6;
    localparam int LEN_W = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } fbg_div_t;

    typedef struct packed {
        logic              carry;
        logic [FRAC_W-1:0] acc;
    } fbg_step_t;

    typedef enum logic {
        FBG_IDLE = 1'b0,
        FBG_RUN  = 1'b1
    } fbg_state_e;

    function automatic fbg_step_t fbg_frac_step(logic [FRAC_W-1:0] acc,
                                                logic [FRAC_W-1:0] frac);
        logic [FRAC_W:0] sum;
        sum = {1'b0, acc} + {1'b0, frac};
        return fbg_step_t'(sum);
    endfunction

    function automatic logic [LEN_W-1:0] fbg_period_len(logic [INT_W-1:0] ipart,
                                                        logic carry);
        return {1'b0, ipart} + LEN_W'(carry);
    endfunction

endpackage

// File: rtl/fbg_frac_accum.sv
module fbg_frac_accum
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);

    logic [FRAC_W-1:0] acc_q;
    fbg_step_t         nxt;

    always_comb begin
        nxt   = fbg_frac_step(acc_q, frac);
        carry = nxt.carry;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= nxt.acc;
        end
    end

    // R4: a carry means the sum wrapped, so the new value falls below the added fraction
    assert_carry_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && carry) |=> (acc_q < $past(frac)));

    // R4: without a carry the sum did not wrap
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && !carry) |=> (acc_q >= $past(frac)));

    // R5: the accumulator holds while no period starts
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!step && !clear) |=> $stable(acc_q));

    // R2: a stopped generator leaves the accumulator at zero
    assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc_q == '0));

endmodule

// File: rtl/fbg_period_ctr.sv
module fbg_period_ctr
    import fbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start_ok,
    input  logic [LEN_W-1:0] len_in,
    output logic             load,
    output logic             tick
);

    fbg_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             running;

    always_comb begin
        running = (state_q == FBG_RUN);
        tick    = running && (cnt_q == len_q);
        load    = en && (!running || tick);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= FBG_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
        end else if (load) begin
            if (start_ok) begin
                state_q <= FBG_RUN;
                cnt_q   <= LEN_W'(1);
                len_q   <= len_in;
            end else begin
                state_q <= FBG_IDLE;
                cnt_q   <= '0;
                len_q   <= '0;
            end
        end else if (running) begin
            cnt_q <= cnt_q + LEN_W'(1);
        end
    end

    // R3: the position within a running period never passes its length
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        running |-> ((cnt_q >= LEN_W'(1)) && (cnt_q <= len_q)));

    // R6: inside a period the length is frozen and the count advances by one
    assert_period_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (en && running && !tick) |=> ($stable(len_q) && (cnt_q == $past(cnt_q) + LEN_W'(1))));

    // R7: a tick closes its period and a new one starts directly, or the generator stops
    assert_back_to_back_R7: assert property (@(posedge clk) disable iff (rst)
        (en && tick && start_ok) |=> (running && (cnt_q == LEN_W'(1))));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);

    fbg_div_t         div_in;
    logic             nonzero;
    logic             load;
    logic             step;
    logic             carry;
    logic [LEN_W-1:0] len_in;

    always_comb begin
        div_in  = '{ipart: div_int, fpart: div_frac};
        nonzero = |div_in.ipart;
        step    = load && nonzero;
        len_in  = fbg_period_len(div_in.ipart, carry);
    end

    fbg_frac_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .clear (!en),
        .step  (step),
        .frac  (div_in.fpart),
        .carry (carry)
    );

    fbg_period_ctr u_period (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .start_ok (nonzero),
        .len_in   (len_in),
        .load     (load),
        .tick     (tick)
    );

    // R1: reset leaves no pulse behind
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !tick);

    // R2: a disabled cycle is followed by a quiet cycle
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tick);

    // R5: loading a zero whole part gives no pulse in the next cycle
    assert_zero_div_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (load && !nonzero) |=> !tick);

endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
    import fbg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en = 1'b0;
    logic [INT_W-1:0]  div_int = '0;
    logic [FRAC_W-1:0] div_frac = '0;
    logic              tick;

    int    cyc = 0;
    int    vectors = 0;
    int    miscompares = 0;
    int    acc_m = 0;
    int    base = 0;
    int    exp_q[$];
    string tag_q[$];

    frac_baud_gen uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .div_int  (div_int),
        .div_frac (div_frac),
        .tick     (tick)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // scoreboard monitor: compares every sampled tick with the queued cycle numbers
    always @(negedge clk) begin
        if (!rst) begin
            while (exp_q.size() > 0 && exp_q[0] < cyc) begin
                miscompares++;
                $display("FAIL %s: actual no tick expected tick in cycle %0d", tag_q[0], exp_q[0]);
                void'(exp_q.pop_front());
                void'(tag_q.pop_front());
            end
            if (tick) begin
                if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                    vectors++;
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end else begin
                    miscompares++;
                    $display("FAIL %s: actual tick in cycle %0d expected %0d",
                             (tag_q.size() > 0) ? tag_q[0] : "R2",
                             cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
                end
            end
        end
    end

    // driver: works out the tick cycles of n periods from the requirements
    task automatic push_periods(input int i_val, input int f_val, input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            int sum;
            int c;
            sum   = acc_m + f_val;
            c     = (sum >= 64) ? 1 : 0;
            acc_m = sum % 64;
            base  = base + i_val + c;
            exp_q.push_back(base);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // starts a run from the stopped state in the current falling-edge cycle
    task automatic fresh(input int i_val, input int f_val);
        en       = 1'b1;
        div_int  = INT_W'(i_val);
        div_frac = FRAC_W'(f_val);
        acc_m    = 0;
        base     = cyc;
    endtask

    task automatic stop_idle(input int n);
        en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R1", int'(tick), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tick == 1'b0, "R1", int'(tick), 0);
        repeat (4) @(negedge clk);
        check(tick == 1'b0, "R1", int'(tick), 0);

        // R3: integer divisor only
        fresh(4, 0);
        push_periods(4, 0, 5, "R3");
        wait_cyc(base);
        stop_idle(6);

        // R7: ticks in every cycle
        fresh(1, 0);
        push_periods(1, 0, 8, "R7");
        wait_cyc(base);
        stop_idle(4);

        // R4: 64 periods average out to the fractional ratio
        fresh(3, 21);
        t0 = base;
        push_periods(3, 21, 64, "R4");
        check((base - t0) == 64 * 3 + 21, "R4", base - t0, 64 * 3 + 21);
        wait_cyc(base);
        stop_idle(4);

        // R4 and R7: alternating stretched periods of 1 and 2 cycles
        fresh(1, 32);
        push_periods(1, 32, 6, "R4");
        wait_cyc(base);
        stop_idle(4);

        // R6: changes inside a period wait for the boundary
        fresh(5, 10);
        push_periods(5, 10, 3, "R6");
        wait_cyc(base - 3);
        div_int  = 16'd9;
        div_frac = 6'd60;
        @(negedge clk);
        div_int  = 16'd7;
        div_frac = 6'd40;
        push_periods(7, 40, 3, "R6");
        wait_cyc(base - 1);
        div_int  = 16'd2;
        div_frac = 6'd0;
        push_periods(2, 0, 3, "R6");
        wait_cyc(base);
        stop_idle(4);

        // R2: a stop inside a period clears the accumulator
        fresh(6, 32);
        push_periods(6, 32, 1, "R2");
        wait_cyc(base + 3);
        stop_idle(10);
        fresh(6, 32);
        push_periods(6, 32, 2, "R2");
        wait_cyc(base);

        // R5: a zero whole part suppresses ticks and holds the accumulator
        div_int  = 16'd0;
        div_frac = 6'd5;
        repeat (15) @(negedge clk);
        div_int  = 16'd3;
        div_frac = 6'd40;
        base     = cyc;
        push_periods(3, 40, 4, "R5");
        wait_cyc(base);
        stop_idle(4);

        // R8: full-width whole part
        fresh(300, 63);
        push_periods(300, 63, 2, "R8");
        wait_cyc(base);
        stop_idle(4);
        fresh(65535, 0);
        push_periods(65535, 0, 1, "R8");
        wait_cyc(base);
        stop_idle(8);

        check(exp_q.size() == 0, "R3", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule